// File: doc/BRIEF.md
# Transition Phase Detector and Data Retimer

This block retimes a 32 kbit/s serial data stream and measures how the local bit clock sits against the data transitions. It runs from one fast system clock. A counter marks a 64 kHz tick every `TICK_DIV` cycles. From that tick the block builds two half-rate bit clocks. `rt_clk` toggles on the tick. `q_clk` toggles half a tick later, so it trails `rt_clk` by a quarter bit. The sliced input is synchronised and then held inverted in a first flop that loads on each rising edge of `rt_clk`. A second flop keeps the value from the bit before.

The error pulse is high whenever the synchronised live data differs from the retimed bit. It therefore starts at a data transition and ends at the next `rt_clk` rise, so its width depends on where the clock falls inside the bit. The reference pulse is high while `q_clk` is high and the two retimed stages disagree, which always gives a width of `TICK_DIV` cycles.

For each transition the block counts both widths in system cycles. When the reference pulse ends, it presents their signed difference as a phase word with a one-cycle strobe. A word of zero means the clock samples in the middle of the bit. All of this runs only while the orderwire mode enable is high.

Top module: `xphase_retimer`

## Requirements
- R1: After `en` rises, `rt_clk` goes high at the first enabled edge and then toggles every `TICK_DIV` enabled cycles, for a bit period of 2·`TICK_DIV` cycles.
- R2: `q_clk` starts low and toggles `TICK_DIV`/2 cycles after each `rt_clk` toggle, so the two clocks never change on the same edge.
- R3: `din` passes through `SYNC_STAGES` flops. `rt_data` takes the synchronised value seen at each rising edge of `rt_clk` and holds it until the next rising edge.
- R4: `err_pulse` is high exactly while the synchronised data differs from `rt_data`. A transition that first reaches the detector o cycles after an `rt_clk` rise edge (1 ≤ o ≤ 2·`TICK_DIV`) gives an error pulse of 2·`TICK_DIV`+1−o cycles.
- R5: `ref_pulse` is high while `q_clk` is high and `rt_data` differs from the bit before it. Every reference pulse lasts exactly `TICK_DIV` cycles.
- R6: In the cycle after the last reference cycle, `phase_vld` is high for one cycle. `phase` then holds the error width minus the reference width (two's complement), which is `TICK_DIV`+1−o. `phase` keeps that value until the next strobe.
- R7: A bit period without a data transition produces no reference pulse and no strobe.
- R8: While `en` is low, all internal state is cleared and `din` is ignored. `rt_clk`, `q_clk`, `rt_data`, `err_pulse`, `ref_pulse`, `phase_vld` and `phase` are all 0.
- R9: A synchronous reset (`rst` high) leaves the block in the same cleared state, and that includes the synchroniser. The idle line level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Orderwire mode enable; low clears and freezes the block |
| din | input | 1 | Sliced serial data |
| rt_clk | output | 1 | Retiming bit clock (first clock) |
| q_clk | output | 1 | Quadrature bit clock, a quarter bit behind `rt_clk` |
| rt_data | output | 1 | Retimed data |
| err_pulse | output | 1 | Phase error pulse |
| ref_pulse | output | 1 | Fixed-width reference pulse |
| phase_vld | output | 1 | One-cycle strobe for a new phase word |
| phase | output | PHASE_W | Signed error width minus reference width |

## Verification
The clocks and `rt_data` move on the edge that follows their tick, and the error and reference pulses follow the registered state in the same cycle. A change on `din` reaches the detector `SYNC_STAGES` edges after it is driven. The phase strobe for a transition appears 3·`TICK_DIV`/2 cycles after the `rt_clk` rise that ends its error pulse. The bench drives inputs and samples on the falling clock edge. It advances a behavioural model by one edge per cycle, so every output is compared in the cycle it is due. Each strobe is also checked against the closed-form value `TICK_DIV`+1−o, using the offset at which the bench placed the transition.

// File: rtl/xpr_pkg.sv
package xpr_pkg;

   // strobes marking the two edges of the 64 kHz master tick
   typedef struct packed {
      logic rise;
      logic fall;
   } tick_t;

   // width of a counter that must hold values 0..max_val
   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/xpr_tick_gen.sv
module xpr_tick_gen
   import xpr_pkg::*;
#(
   parameter int TICK_DIV = 782
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  en,
   output tick_t tk,
   output logic  c1,
   output logic  c2
);
   localparam int CW   = cnt_width(TICK_DIV - 1);
   localparam int HALF = TICK_DIV / 2;

   generate
      if (TICK_DIV < 4 || (TICK_DIV % 2) != 0) begin : g_bad_div
         $error("TICK_DIV must be even and at least 4");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_comb begin
      tk.rise = en && (cnt == '0);
      tk.fall = en && (cnt == CW'(HALF));
   end

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         cnt <= '0;
         c1  <= 1'b0;
         c2  <= 1'b0;
      end else begin
         cnt <= (cnt == CW'(TICK_DIV - 1)) ? '0 : cnt + 1'b1;
         if (tk.rise) c1 <= ~c1;
         if (tk.fall) c2 <= ~c2;
      end
   end

   // R1: the bit clock only moves on a master tick while enabled
   assert_c1_on_tick_R1: assert property (@(posedge clk) disable iff (rst)
      ($past(en) && !$stable(c1)) |-> $past(tk.rise));

   // R2: the quadrature clocks never change on the same edge
   assert_quadrature_R2: assert property (@(posedge clk) disable iff (rst)
      $past(en) |-> !(!$stable(c1) && !$stable(c2)));

endmodule

// File: rtl/xpr_sampler.sv
module xpr_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic din,
   input  logic c1_up,
   input  logic c2,
   output logic rt_data,
   output logic err,
   output logic refp
);
   logic d_s;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_nosync
         assign d_s = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk) begin
            if (rst) sr <= '0;
            else     sr <= {sr[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], din};
         end
         assign d_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   // first stage holds the inverted data, second stage the bit before
   logic q1_n, q2_n;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         q1_n <= 1'b1;
         q2_n <= 1'b1;
      end else if (c1_up) begin
         q1_n <= ~d_s;
         q2_n <= q1_n;
      end
   end

   assign rt_data = ~q1_n;
   assign err     = en && (d_s == q1_n);
   assign refp    = en && c2 && (q1_n != q2_n);

endmodule

// File: rtl/xpr_width_meter.sv
module xpr_width_meter #(
   parameter int TICK_DIV = 782,
   parameter int PHASE_W  = 12
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               c1_up,
   input  logic               c2_down,
   input  logic               err,
   input  logic               refp,
   output logic               vld,
   output logic [PHASE_W-1:0] phase
);
   localparam int CW = xpr_pkg::cnt_width(2 * TICK_DIV + 1);

   generate
      if (PHASE_W < CW + 1) begin : g_bad_pw
         $error("PHASE_W too narrow for the width difference");
      end
   endgenerate

   logic [CW-1:0] err_cnt, err_len, ref_cnt;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         err_cnt <= '0;
         err_len <= '0;
         ref_cnt <= '0;
         vld     <= 1'b0;
         phase   <= '0;
      end else begin
         // an error pulse always closes on the bit clock rise
         if (c1_up) begin
            err_len <= err_cnt + CW'(err);
            err_cnt <= '0;
         end else begin
            err_cnt <= err_cnt + CW'(err);
         end
         // the reference pulse always closes on the quadrature fall
         if (refp && c2_down) begin
            phase   <= PHASE_W'(err_len) - PHASE_W'(ref_cnt) - PHASE_W'(1);
            vld     <= 1'b1;
            ref_cnt <= '0;
         end else begin
            ref_cnt <= ref_cnt + CW'(refp);
            vld     <= 1'b0;
         end
      end
   end

   // R6: each phase word is flagged for a single cycle
   assert_vld_single_R6: assert property (@(posedge clk) disable iff (rst)
      vld |=> !vld);

endmodule

// File: rtl/xphase_retimer.sv
module xphase_retimer
   import xpr_pkg::*;
#(
   parameter int TICK_DIV    = 782,
   parameter int SYNC_STAGES = 2,
   parameter int PHASE_W     = cnt_width(2 * TICK_DIV + 1) + 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               din,
   output logic               rt_clk,
   output logic               q_clk,
   output logic               rt_data,
   output logic               err_pulse,
   output logic               ref_pulse,
   output logic               phase_vld,
   output logic [PHASE_W-1:0] phase
);
   localparam int RW = cnt_width(TICK_DIV + 1);

   tick_t tk;
   logic  c1, c2, c1_up, c2_down;

   xpr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .tk  (tk),
      .c1  (c1),
      .c2  (c2)
   );

   assign c1_up   = tk.rise && !c1;
   assign c2_down = tk.fall && c2;

   xpr_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .din     (din),
      .c1_up   (c1_up),
      .c2      (c2),
      .rt_data (rt_data),
      .err     (err_pulse),
      .refp    (ref_pulse)
   );

   xpr_width_meter #(.TICK_DIV(TICK_DIV), .PHASE_W(PHASE_W)) u_meter (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .c1_up   (c1_up),
      .c2_down (c2_down),
      .err     (err_pulse),
      .refp    (ref_pulse),
      .vld     (phase_vld),
      .phase   (phase)
   );

   assign rt_clk = c1;
   assign q_clk  = c2;

   // checker counter: length of the reference pulse in progress
   logic [RW-1:0] ref_run;
   always_ff @(posedge clk) begin
      if (rst || !en)     ref_run <= '0;
      else if (ref_pulse) ref_run <= ref_run + 1'b1;
      else                ref_run <= '0;
   end

   // R5: a reference pulse that ends normally spans TICK_DIV cycles
   assert_ref_width_R5: assert property (@(posedge clk) disable iff (rst)
      ($past(ref_pulse) && !ref_pulse && en && $past(en)) |-> (ref_run == RW'(TICK_DIV)));

   // R8: one cycle after a disabled edge everything is quiet
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      !$past(en) |-> (!rt_clk && !q_clk && !phase_vld && !rt_data));

endmodule

// File: tb/tb_xphase_retimer.sv
module tb_xphase_retimer;
   localparam int N  = 8;
   localparam int S  = 2;
   localparam int PW = xpr_pkg::cnt_width(2 * N + 1) + 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic din = 1'b0;
   logic rt_clk, q_clk, rt_data, err_pulse, ref_pulse, phase_vld;
   logic signed [PW-1:0] phase;

   xphase_retimer #(.TICK_DIV(N), .SYNC_STAGES(S), .PHASE_W(PW)) dut (
      .clk (clk), .rst (rst), .en (en), .din (din),
      .rt_clk (rt_clk), .q_clk (q_clk), .rt_data (rt_data),
      .err_pulse (err_pulse), .ref_pulse (ref_pulse),
      .phase_vld (phase_vld), .phase (phase)
   );

   always #10 clk = ~clk;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 60000 && !done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 60000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
      end
   endtask

   // behavioural reference state
   int  n;
   bit  m_c1, m_c2, m_held, m_heldp, m_vld;
   int  m_errrun, m_errlen, m_refrun, m_phase;
   bit  hist[S];
   int  expq[$];
   bit  ds_now;

   task automatic m_clear();
      n = 0; m_c1 = 0; m_c2 = 0; m_held = 0; m_heldp = 0; m_vld = 0;
      m_errrun = 0; m_errlen = 0; m_refrun = 0; m_phase = 0;
   endtask

   task automatic step();
      bit en_e, rst_e, din_e, dsp, rise, fall, errp, refp, c1up;
      int idx;
      en_e = en; rst_e = rst; din_e = din;
      dsp = hist[S-1];
      @(negedge clk);
      if (rst_e || !en_e) begin
         m_clear();
      end else begin
         idx  = n; n++;
         rise = (idx % N) == 0;
         fall = (idx % N) == N / 2;
         c1up = rise && !m_c1;
         errp = (dsp != m_held);
         refp = m_c2 && (m_held != m_heldp);
         m_vld = refp && fall;
         if (m_vld) begin
            m_phase  = m_errlen - (m_refrun + 1);
            m_refrun = 0;
         end else m_refrun += int'(refp);
         if (c1up) begin
            m_errlen = m_errrun + int'(errp);
            m_errrun = 0;
            m_heldp  = m_held;
            m_held   = dsp;
         end else m_errrun += int'(errp);
         if (rise) m_c1 = !m_c1;
         if (fall) m_c2 = !m_c2;
      end
      for (int i = S - 1; i > 0; i--) hist[i] = rst_e ? 1'b0 : hist[i-1];
      hist[0] = rst_e ? 1'b0 : din_e;
      ds_now = hist[S-1];
      // cycle-by-cycle comparison
      check("R1 rt_clk", int'(rt_clk), int'(m_c1));
      check("R2 q_clk", int'(q_clk), int'(m_c2));
      check("R3 rt_data", int'(rt_data), int'(m_held));
      check("R4 err_pulse", int'(err_pulse), int'(en && (ds_now != m_held)));
      check("R5 ref_pulse", int'(ref_pulse), int'(en && m_c2 && (m_held != m_heldp)));
      check("R6 phase_vld", int'(phase_vld), int'(m_vld));
      check("R6 phase", int'(phase), m_phase);
      // closed-form check of each phase word against the placed offset
      if (phase_vld && !rst_e && en_e) begin
         if (expq.size() == 0) check("R7 strobe without transition", 1, 0);
         else check("R6 phase vs offset", int'(phase), expq.pop_front());
      end
   endtask

   // place a transition so it reaches the detector o cycles after rise k
   task automatic xfer(input int o, input int k);
      int target;
      target = 2 * N * k + o - 2;
      while (n < target) step();
      din = ~din;
      expq.push_back(N + 1 - o);
   endtask

   task automatic run_seg(input int o, input int cnt, inout int k);
      for (int i = 0; i < cnt; i++) begin
         xfer(o, k);
         k++;
      end
   endtask

   task automatic idle_slots(input int slots);
      for (int i = 0; i < slots * 2 * N; i++) step();
   endtask

   initial begin
      int k;
      m_clear();
      for (int i = 0; i < S; i++) hist[i] = 1'b0;
      // R9: reset state
      repeat (4) step();
      check("R9 reset phase_vld", int'(phase_vld), 0);
      check("R9 reset rt_clk", int'(rt_clk), 0);
      rst = 1'b0;
      repeat (3) step();
      en = 1'b1;
      k = 1;
      // R4 R6: several offsets, from late to centred to early
      run_seg(1, 4, k);
      run_seg(2 * N, 4, k);
      run_seg(N + 1, 4, k);
      run_seg(4, 3, k);
      run_seg(12, 3, k);
      // R7: bit periods with no transition give no strobe
      idle_slots(5);
      k += 5 + 1;
      check("R7 queue drained after idle", expq.size(), 0);
      // sparse pattern: transitions separated by quiet bits
      for (int i = 0; i < 4; i++) begin
         xfer(3 + 2 * i, k);
         k += 3;
      end
      idle_slots(4);
      check("R7 sparse strobes matched", expq.size(), 0);
      // R8: disabled block ignores data
      en = 1'b0;
      repeat (3) step();
      for (int i = 0; i < 10; i++) begin
         din = ~din;
         repeat (5) step();
         check("R8 disabled rt_clk", int'(rt_clk), 0);
         check("R8 disabled err_pulse", int'(err_pulse), 0);
         check("R8 disabled phase_vld", int'(phase_vld), 0);
      end
      din = 1'b0;
      repeat (4) step();
      en = 1'b1;
      k = 1;
      run_seg(6, 5, k);
      idle_slots(3);
      // R9: reset in the middle of traffic
      xfer(10, k);
      repeat (3) step();
      rst = 1'b1;
      din = 1'b0;
      expq.delete();
      repeat (3) step();
      check("R9 mid reset phase", int'(phase), 0);
      rst = 1'b0;
      k = 1;
      run_seg(N, 4, k);
      idle_slots(3);
      check("R6 all strobes seen", expq.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule